// File: doc/BRIEF.md
# EDO DRAM Controller

This block sits between a simple host request port and one 16-Mbit, 4-bit-wide extended-data-out DRAM. The host offers one request at a time: an address, a write flag and write data. The controller splits the address into a row half and a column half and drives both onto a shared 12-bit address bus. It then sequences the active-low row strobe, column strobe, write enable and output enable. Finished reads are returned with a one-cycle valid pulse.

The controller keeps a row open after an access. A following request to the same row is served by cycling only the column strobe. A request to a different row closes the row and opens the new one. A free-running interval counter raises a refresh request. When that request is set, the controller closes any open row and runs one refresh cycle in which the column strobe falls before the row strobe. It accepts no host request until that refresh is done.

All device timing limits are parameters given in whole clock cycles. A parameter also chooses between the two address geometries: 11 row bits by 11 column bits, or 12 row bits by 10 column bits.

Top module: `edo_ctrl`

## Requirements
- R1: At a row-strobe fall the bus carries the row, `req_addr[21:CW]`. At a column-strobe fall it carries the column, `req_addr[CW-1:0]`, with bus bits at or above CW driven to zero. CW is 10 with GEOM_4K=1 and 11 with GEOM_4K=0.
- R2: After reset, every strobe (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) is high, `dram_dq_oe` is low and `rd_valid` is low.
- R3: Read data is captured only when at least T_RAC cycles have passed since the row strobe fell and at least T_CAC cycles since the column strobe fell. The data is returned with a `rd_valid` pulse of exactly one cycle, and reads complete in request order.
- R4: Two successive column-strobe falls are at least T_PC cycles apart.
- R5: The column strobe stays low for at least T_CAS cycles.
- R6: The row strobe stays high for at least T_RP cycles before each fall.
- R7: Two successive row-strobe falls are at least T_RC cycles apart.
- R8: A request to the row that is already open is served with a column-strobe cycle only, without a new row-strobe fall.
- R9: A refresh pulls the column strobe low at least one cycle before the row strobe falls, with `dram_we_n` high. Refreshes repeat every REF_INTERVAL cycles, each served within 60 cycles of being requested.
- R10: On a write, `dram_we_n` is low at least one cycle before the column strobe falls, and the data lines are driven while it is low. `dram_oe_n` stays high whenever `dram_we_n` is low. The written data is later read back from the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this cycle when valid is also high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 4 | Returned read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven toward the device |
| dram_dq_oe | output | 1 | High while the controller drives the data lines |
| dram_dq_in | input | 4 | Data returned by the device |

## Verification
The bench builds the block with the 12-by-10 geometry, so the 12-bit row fills the whole bus and every column check also covers the zeroed top bus bits. The timing parameters keep their defaults, which correspond to the faster speed grade at a 5 ns clock. The refresh interval is cut to 300 cycles. With that interval, refreshes fall inside page bursts, row misses and random traffic many times per run, so row closure, refresh ordering and the return to host traffic are exercised again and again in a short run. The device stub returns wrong data whenever a capture comes earlier than the access limits allow.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;
  localparam int ADDR_W = 22;
  localparam int BUS_W  = 12;
  localparam int DQ_W   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_CSET, ST_CAS, ST_COL, ST_OPEN, ST_REF1, ST_REF2
  } seq_state_t;

  function automatic int row_bits(bit g4k);
    return g4k ? 12 : 11;
  endfunction

  function automatic int col_bits(bit g4k);
    return g4k ? 10 : 11;
  endfunction
endpackage

// File: rtl/edo_addr_split.sv
`timescale 1ns/1ps
module edo_addr_split
  import edo_pkg::*;
#(
  parameter bit GEOM_4K = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BUS_W-1:0]  row,
  output logic [BUS_W-1:0]  col
);
  localparam int RB = row_bits(GEOM_4K);
  localparam int CB = col_bits(GEOM_4K);

  generate
    if (CB < BUS_W) begin : g_col_pad
      assign col = {{(BUS_W-CB){1'b0}}, addr[CB-1:0]};
    end else begin : g_col_full
      assign col = addr[CB-1:0];
    end
    if (RB < BUS_W) begin : g_row_pad
      assign row = {{(BUS_W-RB){1'b0}}, addr[ADDR_W-1:CB]};
    end else begin : g_row_full
      assign row = addr[ADDR_W-1:CB];
    end
  endgenerate
endmodule

// File: rtl/edo_ref_timer.sv
`timescale 1ns/1ps
module edo_ref_timer #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic pending
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          pend_d;
  logic          tick;

  always_comb begin
    tick   = (cnt_q == TW'(INTERVAL - 1));
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    pend_d = pending;
    if (served) pend_d = 1'b0;
    if (tick)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/edo_seq.sv
`timescale 1ns/1ps
module edo_seq
  import edo_pkg::*;
#(
  parameter int T_RAC = 10,
  parameter int T_CAC = 3,
  parameter int T_CAS = 2,
  parameter int T_PC  = 4,
  parameter int T_RC  = 17,
  parameter int T_RP  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [DQ_W-1:0]  req_wdata,
  input  logic [BUS_W-1:0] row,
  input  logic [BUS_W-1:0] col,
  output logic             req_ready,
  input  logic             ref_pend,
  output logic             ref_done,
  output logic             rd_valid,
  output logic [DQ_W-1:0]  rd_data,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [BUS_W-1:0] bus_addr,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  input  logic [DQ_W-1:0]  dq_in
);
  localparam int CW = $clog2(T_RC + T_RP + T_RAC + T_PC + 1) + 1;

  seq_state_t       st_q, st_d;
  logic             ras_q, ras_d, cas_q, cas_d, wen_q, wen_d, oen_q, oen_d;
  logic             dqoe_q, dqoe_d, we_q, we_d, rdv_q, rdv_d;
  logic [DQ_W-1:0]  dqo_q, dqo_d, wd_q, wd_d, rdat_q, rdat_d;
  logic [BUS_W-1:0] addr_q, addr_d, open_q, open_d, col_q, col_d;
  logic [CW-1:0]    tras_q, tras_d, tcas_q, tcas_d, tpre_q, tpre_d;

  function automatic logic [CW-1:0] sat_inc(logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign req_ready = ((st_q == ST_IDLE) || (st_q == ST_OPEN)) && !ref_pend;
  assign ref_done  = (st_q == ST_REF2) && (tras_q >= CW'(T_RAC));

  always_comb begin
    st_d   = st_q;   ras_d  = ras_q;  cas_d  = cas_q;  wen_d = wen_q;
    oen_d  = oen_q;  dqoe_d = dqoe_q; dqo_d  = dqo_q;  we_d  = we_q;
    wd_d   = wd_q;   addr_d = addr_q; open_d = open_q; col_d = col_q;
    rdat_d = rdat_q; rdv_d  = 1'b0;
    tras_d = sat_inc(tras_q);
    tcas_d = sat_inc(tcas_q);
    tpre_d = sat_inc(tpre_q);
    case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          if (tpre_q >= CW'(T_RP) && tras_q >= CW'(T_RC) && tcas_q >= CW'(T_PC)) begin
            cas_d  = 1'b0;
            tcas_d = CW'(1);
            st_d   = ST_REF1;
          end
        end else if (req_valid) begin
          addr_d = row; open_d = row; col_d = col;
          we_d   = req_we; wd_d = req_wdata;
          st_d   = ST_ACT;
        end
      end
      ST_ACT: begin
        if (tpre_q >= CW'(T_RP) && tras_q >= CW'(T_RC)) begin
          ras_d  = 1'b0;
          tras_d = CW'(1);
          st_d   = ST_CSET;
        end
      end
      ST_CSET: begin
        addr_d = col_q; wen_d = ~we_q; oen_d = we_q;
        dqoe_d = we_q;  dqo_d = wd_q;
        st_d   = ST_CAS;
      end
      ST_CAS: begin
        if (tcas_q >= CW'(T_PC)) begin
          cas_d  = 1'b0;
          tcas_d = CW'(1);
          st_d   = ST_COL;
        end
      end
      ST_COL: begin
        if (tcas_q >= CW'(T_CAS) &&
            (we_q || (tras_q >= CW'(T_RAC) && tcas_q >= CW'(T_CAC)))) begin
          cas_d  = 1'b1; wen_d = 1'b1; oen_d = 1'b1; dqoe_d = 1'b0;
          rdv_d  = ~we_q;
          if (!we_q) rdat_d = dq_in;
          st_d   = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (ref_pend) begin
          ras_d  = 1'b1;
          tpre_d = CW'(1);
          st_d   = ST_IDLE;
        end else if (req_valid) begin
          col_d = col; we_d = req_we; wd_d = req_wdata;
          if (row == open_q) begin
            addr_d = col;    wen_d = ~req_we; oen_d = req_we;
            dqoe_d = req_we; dqo_d = req_wdata;
            st_d   = ST_CAS;
          end else begin
            ras_d  = 1'b1;
            tpre_d = CW'(1);
            addr_d = row; open_d = row;
            st_d   = ST_ACT;
          end
        end
      end
      ST_REF1: begin
        ras_d  = 1'b0;
        tras_d = CW'(1);
        st_d   = ST_REF2;
      end
      ST_REF2: begin
        if (tras_q >= CW'(T_RAC)) begin
          ras_d  = 1'b1; cas_d = 1'b1;
          tpre_d = CW'(1);
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE; ras_q <= 1'b1; cas_q <= 1'b1; wen_q <= 1'b1;
      oen_q  <= 1'b1;    dqoe_q <= 1'b0; dqo_q <= '0;  we_q  <= 1'b0;
      wd_q   <= '0;      addr_q <= '0;   open_q <= '0; col_q <= '0;
      rdat_q <= '0;      rdv_q  <= 1'b0;
      tras_q <= '0;      tcas_q <= '0;   tpre_q <= '0;
    end else begin
      st_q   <= st_d;    ras_q  <= ras_d;  cas_q  <= cas_d;  wen_q <= wen_d;
      oen_q  <= oen_d;   dqoe_q <= dqoe_d; dqo_q  <= dqo_d;  we_q  <= we_d;
      wd_q   <= wd_d;    addr_q <= addr_d; open_q <= open_d; col_q <= col_d;
      rdat_q <= rdat_d;  rdv_q  <= rdv_d;
      tras_q <= tras_d;  tcas_q <= tcas_d; tpre_q <= tpre_d;
    end
  end

  assign ras_n    = ras_q;
  assign cas_n    = cas_q;
  assign we_n     = wen_q;
  assign oe_n     = oen_q;
  assign bus_addr = addr_q;
  assign dq_out   = dqo_q;
  assign dq_oe    = dqoe_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdat_q;
endmodule

// File: rtl/edo_ctrl.sv
`timescale 1ns/1ps
module edo_ctrl
  import edo_pkg::*;
#(
  parameter bit GEOM_4K      = 1'b0,
  parameter int T_RAC        = 10,
  parameter int T_CAC        = 3,
  parameter int T_CAS        = 2,
  parameter int T_PC         = 4,
  parameter int T_RC         = 17,
  parameter int T_RP         = 6,
  parameter int REF_INTERVAL = 1560
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_we,
  input  logic [21:0] req_addr,
  input  logic [3:0]  req_wdata,
  output logic        rd_valid,
  output logic [3:0]  rd_data,
  output logic        dram_ras_n,
  output logic        dram_cas_n,
  output logic        dram_we_n,
  output logic        dram_oe_n,
  output logic [11:0] dram_addr,
  output logic [3:0]  dram_dq_out,
  output logic        dram_dq_oe,
  input  logic [3:0]  dram_dq_in
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [BUS_W-1:0] row_w, col_w;
  logic             ref_pend, ref_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  edo_addr_split #(.GEOM_4K(GEOM_4K)) u_split (
    .addr (req_addr),
    .row  (row_w),
    .col  (col_w)
  );

  edo_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .served  (ref_done),
    .pending (ref_pend)
  );

  edo_seq #(
    .T_RAC(T_RAC), .T_CAC(T_CAC), .T_CAS(T_CAS),
    .T_PC(T_PC),   .T_RC(T_RC),   .T_RP(T_RP)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .row       (row_w),
    .col       (col_w),
    .req_ready (req_ready),
    .ref_pend  (ref_pend),
    .ref_done  (ref_done),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .bus_addr  (dram_addr),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe),
    .dq_in     (dram_dq_in)
  );
endmodule

// File: rtl/edo_ctrl_chk.sv
`timescale 1ns/1ps
module edo_ctrl_chk #(
  parameter int T_RAC = 10,
  parameter int T_CAC = 3,
  parameter int T_CAS = 2,
  parameter int T_PC  = 4,
  parameter int T_RC  = 17,
  parameter int T_RP  = 6
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic rd_valid
);
  logic [15:0] hi_cnt, lo_cnt, rc_cnt, pc_cnt;
  logic        ras_prev, cas_prev;

  function automatic logic [15:0] inc16(logic [15:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0; lo_cnt <= '0; rc_cnt <= '0; pc_cnt <= '0;
      ras_prev <= 1'b1; cas_prev <= 1'b1;
    end else begin
      ras_prev <= ras_n;
      cas_prev <= cas_n;
      hi_cnt   <= ras_n ? inc16(hi_cnt) : '0;
      lo_cnt   <= cas_n ? '0 : inc16(lo_cnt);
      rc_cnt   <= (ras_prev && !ras_n) ? 16'd1 : inc16(rc_cnt);
      pc_cnt   <= (cas_prev && !cas_n) ? 16'd1 : inc16(pc_cnt);
    end
  end

  p_rp_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= 16'(T_RP));

  p_rc_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> rc_cnt >= 16'(T_RC));

  p_pc_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> pc_cnt >= 16'(T_PC));

  p_cas_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> lo_cnt >= 16'(T_CAS));

  p_rd_rac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rc_cnt >= 16'(T_RAC)) && !ras_n);

  p_rd_cac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (pc_cnt >= 16'(T_CAC)) && $rose(cas_n));

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_we_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !we_n) |-> !$past(we_n));

  p_oe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> (!$past(cas_n) && we_n));
endmodule

bind edo_ctrl edo_ctrl_chk #(
  .T_RAC(T_RAC), .T_CAC(T_CAC), .T_CAS(T_CAS),
  .T_PC(T_PC),   .T_RC(T_RC),   .T_RP(T_RP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (dram_ras_n),
  .cas_n    (dram_cas_n),
  .we_n     (dram_we_n),
  .oe_n     (dram_oe_n),
  .rd_valid (rd_valid)
);

// File: tb/edo_ctrl_bench.sv
`timescale 1ns/1ps
module edo_ctrl_bench;
  localparam int P_RAC = 10, P_CAC = 3, P_CAS = 2, P_PC = 4, P_RC = 17, P_RP = 6;
  localparam int P_REF = 300;
  localparam int SLACK = 60;
  localparam int CB = 10, RB = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [21:0] req_addr;
  logic [3:0]  req_wdata;
  logic        req_ready, rd_valid;
  logic [3:0]  rd_data;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [11:0] dram_addr;
  logic [3:0]  dram_dq_out, dram_dq_in;

  always #2.5 clk = ~clk;

  edo_ctrl #(
    .GEOM_4K(1'b1), .T_RAC(P_RAC), .T_CAC(P_CAC), .T_CAS(P_CAS),
    .T_PC(P_PC), .T_RC(P_RC), .T_RP(P_RP), .REF_INTERVAL(P_REF)
  ) u_edo_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [3:0] mem [int];
  logic [3:0] shadow [int];
  int         exp_addr_q [$];
  logic [3:0] exp_data_q [$];
  int t_ras_fall = -1000, t_ras_rise = -1000, t_cas_fall = -1000;
  int ras_lo = 0, cas_lo = 0, cur_a = 0;
  int n_act = 0, n_ref = 0, last_ref = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
  logic [11:0] st_row = '0;

  function automatic logic [3:0] initv(int a);
    return 4'(a) ^ 4'(a >> 4) ^ 4'(a >> 12) ^ 4'h5;
  endfunction
  function automatic logic [3:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : initv(a);
  endfunction
  function automatic logic [3:0] sh_rd(int a);
    return shadow.exists(a) ? shadow[a] : initv(a);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // Reference timing model and device stub, evaluated every clock
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
        chk(cyc - t_ras_rise >= P_RP, "R6", "row strobe high time", cyc - t_ras_rise, P_RP);
        chk(cyc - t_ras_fall >= P_RC, "R7", "row strobe fall spacing", cyc - t_ras_fall, P_RC);
        if (!dram_cas_n) begin
          chk(!prev_cas && dram_we_n, "R9", "column strobe low before row fall, we high",
              {prev_cas, dram_we_n}, 1);
          chk(cyc - last_ref <= P_REF + SLACK, "R9", "refresh gap", cyc - last_ref, P_REF + SLACK);
          n_ref++;
          last_ref = cyc;
        end else begin
          n_act++;
          st_row = dram_addr;
        end
        t_ras_fall = cyc;
      end
      if (!prev_ras && dram_ras_n) t_ras_rise = cyc;
      if (prev_cas && !dram_cas_n) begin
        chk(cyc - t_cas_fall >= P_PC, "R4", "column strobe fall spacing", cyc - t_cas_fall, P_PC);
        t_cas_fall = cyc;
        if (!dram_ras_n) begin
          automatic int a = int'({st_row[RB-1:0], dram_addr[CB-1:0]});
          chk(dram_addr[11:CB] == '0, "R1", "column bus upper bits", int'(dram_addr[11:CB]), 0);
          if (exp_addr_q.size() == 0) chk(0, "R1", "unexpected column access", a, -1);
          else begin
            automatic int e = exp_addr_q.pop_front();
            chk(a == e, "R1", "row/column address", a, e);
          end
          if (!dram_we_n) begin
            chk(!prev_we, "R10", "write enable set up before column strobe", prev_we, 0);
            chk(dram_dq_oe && dram_oe_n, "R10", "data driven and oe high on write",
                {dram_dq_oe, dram_oe_n}, 3);
            mem[a] = dram_dq_out;
          end else begin
            cur_a = a;
          end
        end
      end
      if (!prev_cas && dram_cas_n)
        chk(cyc - t_cas_fall >= P_CAS, "R5", "column strobe width", cyc - t_cas_fall, P_CAS);
      if (rd_valid) begin
        if (exp_data_q.size() == 0) chk(0, "R3", "unexpected read return", int'(rd_data), -1);
        else begin
          automatic logic [3:0] ed = exp_data_q.pop_front();
          chk(rd_data == ed, "R3", "read data", int'(rd_data), int'(ed));
        end
      end
    end
    ras_lo     = dram_ras_n ? 0 : ras_lo + 1;
    cas_lo     = dram_cas_n ? 0 : cas_lo + 1;
    dram_dq_in = (ras_lo >= P_RAC && cas_lo >= P_CAC) ? mem_rd(cur_a) : ~mem_rd(cur_a);
    prev_ras   = dram_ras_n;
    prev_cas   = dram_cas_n;
    prev_we    = dram_we_n;
  end

  task automatic xfer(bit w, int a, logic [3:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = w; req_addr = a[21:0]; req_wdata = d;
    while (!req_ready) @(negedge clk);
    exp_addr_q.push_back(a);
    if (w) shadow[a] = d;
    else   exp_data_q.push_back(sh_rd(a));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_addr_q.size() != 0 || exp_data_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  function automatic int mk(int r, int c);
    return ((r & 12'hFFF) << CB) | (c & 10'h3FF);
  endfunction

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int a0, r0, f0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    // R2: reset state
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R2", "strobes high in reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!dram_dq_oe && !rd_valid, "R2", "no drive, no read return in reset",
        {dram_dq_oe, rd_valid}, 0);
    rst_n = 1'b1;
    last_ref = cyc;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && !rd_valid, "R2", "idle after reset release",
        {dram_ras_n, dram_cas_n, rd_valid}, 6);

    // R1/R10/R3: writes across rows, then read back
    for (int i = 0; i < 6; i++) xfer(1'b1, mk(i * 37 + 5, i * 101), 4'(i + 9));
    for (int i = 0; i < 6; i++) xfer(1'b0, mk(i * 37 + 5, i * 101), 4'h0);
    drain();

    // R8: page burst within one newly opened row
    a0 = n_act; r0 = n_ref;
    for (int i = 0; i < 8; i++) xfer(i[0], mk(12'hABC, i * 7), 4'(i ^ 3));
    drain();
    chk(n_act - a0 >= 1 && n_act - a0 <= 1 + (n_ref - r0), "R8", "activations in page burst",
        n_act - a0, 1);

    // R6/R7: alternating rows force a miss on every access
    a0 = n_act;
    for (int i = 0; i < 10; i++) xfer(i[1], mk(i[0] ? 12'h111 : 12'h222, i), 4'(i));
    drain();
    chk(n_act - a0 >= 10, "R7", "activations on row misses", n_act - a0, 10);

    // R1: corner addresses of the geometry
    xfer(1'b1, 22'h3FFFFF, 4'hE);
    xfer(1'b1, 0, 4'h1);
    xfer(1'b1, mk(12'hFFF, 0), 4'h7);
    xfer(1'b1, mk(0, 10'h3FF), 4'hB);
    xfer(1'b0, 22'h3FFFFF, 4'h0);
    xfer(1'b0, 0, 4'h0);
    xfer(1'b0, mk(12'hFFF, 0), 4'h0);
    xfer(1'b0, mk(0, 10'h3FF), 4'h0);
    drain();

    // Mixed traffic over a few rows, with refreshes interleaved
    for (int i = 0; i < 300; i++) begin
      automatic int r = int'($urandom_range(0, 3)) * 997;
      automatic int c = int'($urandom_range(0, 15));
      xfer($urandom_range(0, 1) == 1, mk(r, c), 4'($urandom));
    end
    drain();

    // R9: idle stretch, refreshes must keep coming
    f0 = n_ref;
    repeat (3 * P_REF) @(negedge clk);
    chk(n_ref - f0 >= 2, "R9", "refreshes while idle", n_ref - f0, 3);
    chk(cyc - last_ref <= P_REF + SLACK, "R9", "time since last refresh", cyc - last_ref, P_REF);
    chk(exp_addr_q.size() == 0 && exp_data_q.size() == 0, "R3", "all requests completed",
        exp_addr_q.size() + exp_data_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule